// File: doc/BRIEF.md
# Multi-Resolution One-Shot Delay Timer

This block is a polled delay timer that sits on a small processor's 8-bit peripheral bus. Software writes an 8-bit count into one of three register addresses. The address it picks sets the unit of the count: microseconds, milliseconds or seconds. The write loads the count and starts a single countdown. Software then reads the block until the busy flag in bit 0 drops. When the countdown ends, the timer stays idle until software writes to it again. It never reloads by itself.

A prescaler chain divides the system clock into a one-cycle microsecond tick. Two further stages divide that tick down to millisecond and second ticks. Every loading write restarts the prescaler, so the first tick of a new delay arrives one full tick period after the write. A delay of N units therefore lasts exactly N unit periods. An external address decoder drives the chip-select input.

Top module: `oneshot_delay_timer`

## Requirements
- R1: After a synchronous active-low reset, `rdata` reads 8'h00 (idle, count cleared).
- R2: A selected write (`sel`=1, `wr_en`=1) with `reg_sel`=0 and value N>0 sets busy on the next clock edge. Busy falls exactly N×(CLK_HZ/1e6) clock edges after the write edge.
- R3: A selected write with `reg_sel`=1 and value N>0 holds busy for exactly N×(CLK_HZ/1e6)×US_PER_MS clock edges.
- R4: A selected write with `reg_sel`=2 and value N>0 holds busy for exactly N×(CLK_HZ/1e6)×US_PER_MS×MS_PER_S clock edges.
- R5: A selected write with `reg_sel`=3 has no effect. A running countdown keeps its original end time, and an idle timer stays idle.
- R6: A write with `sel`=0, or with `wr_en`=0, is ignored.
- R7: Writing a count of 0 through `reg_sel` 0, 1 or 2 leaves busy at 0. If the timer is running, this write cancels the countdown.
- R8: A loading write while the timer is running replaces the count and the resolution and restarts the timing from that write.
- R9: `rdata[0]` is the busy flag and `rdata[7:1]` always read 0, whatever the value of `reg_sel`.
- R10: One-shot behaviour: once busy has fallen, it stays at 0 until the next loading write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Chip select from the external address decoder |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 2 | Register select: 0 = µs, 1 = ms, 2 = s, 3 = unused |
| wdata | input | 8 | Count to load |
| rdata | output | 8 | Status: bit 0 = busy, bits 7:1 = 0 |

## Verification
The bench keeps a behavioural count of the remaining cycles, sets it on every loading write and compares the status on every clock. This catches a prescaler that is not restarted by a write: such a design ends the first unit early by a random phase offset. The bench also rewrites the timer during a millisecond delay and ends on a microsecond count. A design that keeps the old resolution or the old count would hold busy far too long. Writes to the unused address, unselected writes and writes with the strobe low are all sent during a running delay. A design that decodes the address loosely would restart or cancel that delay. Counts of 0, 1 and 255 check for an off-by-one at either end of the count range and for a timer that never stops.

// File: rtl/odt_pkg.sv
package odt_pkg;

  typedef enum logic [1:0] {
    RES_US  = 2'd0,
    RES_MS  = 2'd1,
    RES_S   = 2'd2,
    RES_NOP = 2'd3
  } res_e;

  localparam int unsigned NUM_STAGES = 3;

  // Divisor of prescaler stage idx: clock->us, us->ms, ms->s.
  function automatic int unsigned stage_div(input int unsigned idx,
                                            input int unsigned clk_hz,
                                            input int unsigned us_per_ms,
                                            input int unsigned ms_per_s);
    int unsigned d;
    case (idx)
      0:       d = clk_hz / 1_000_000;
      1:       d = us_per_ms;
      default: d = ms_per_s;
    endcase
    if (d == 0) d = 1;
    return d;
  endfunction

  // Register selects that load a count.
  function automatic logic is_load_reg(input logic [1:0] rs);
    return rs != RES_NOP;
  endfunction

endpackage

// File: rtl/odt_divstage.sv
module odt_divstage #(
  parameter int unsigned DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick_in,
  output logic tick_out
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_out = tick_in && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/odt_countdown.sv
module odt_countdown
  import odt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [DW-1:0]         load_val,
  input  res_e                  load_res,
  input  logic [NUM_STAGES-1:0] ticks,
  output logic [DW-1:0]         count,
  output logic                  busy,
  output logic                  dec_evt
);
  logic [DW-1:0] count_q;
  res_e          res_q;
  logic          unit_tick;

  always_comb begin
    case (res_q)
      RES_US:  unit_tick = ticks[0];
      RES_MS:  unit_tick = ticks[1];
      default: unit_tick = ticks[2];
    endcase
  end

  assign busy    = (count_q != '0);
  assign dec_evt = busy && unit_tick && !load;
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      res_q   <= RES_US;
    end else if (load) begin
      count_q <= load_val;
      res_q   <= load_res;
    end else if (dec_evt) begin
      count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/oneshot_delay_timer.sv
module oneshot_delay_timer
  import odt_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned US_PER_MS = 1000,
  parameter int unsigned MS_PER_S  = 1000,
  parameter int unsigned DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic                  load_evt;
  logic [NUM_STAGES-1:0] ticks;
  logic                  busy;
  logic                  dec_evt;
  logic [DW-1:0]         count_q;
  logic                  us_tick;
  logic                  ms_tick;
  logic                  s_tick;

  assign load_evt = sel && wr_en && is_load_reg(reg_sel);

  for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
    logic tick_in;
    logic tick_out;
    if (gi == 0) begin : g_first
      assign tick_in = 1'b1;
    end else begin : g_next
      assign tick_in = g_stage[gi-1].tick_out;
    end
    odt_divstage #(
      .DIV(stage_div(gi, CLK_HZ, US_PER_MS, MS_PER_S))
    ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load_evt),
      .tick_in (tick_in),
      .tick_out(tick_out)
    );
    assign ticks[gi] = tick_out;
  end

  assign us_tick = ticks[0];
  assign ms_tick = ticks[1];
  assign s_tick  = ticks[2];

  odt_countdown #(.DW(DW)) u_cd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .load_val(wdata),
    .load_res(res_e'(reg_sel)),
    .ticks   (ticks),
    .count   (count_q),
    .busy    (busy),
    .dec_evt (dec_evt)
  );

  assign rdata = {{(DW-1){1'b0}}, busy};
endmodule

// File: rtl/odt_checker.sv
module odt_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          wr_en,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          busy,
  input logic          dec_evt,
  input logic          load_evt,
  input logic [DW-1:0] count_q,
  input logic          us_tick,
  input logic          ms_tick,
  input logic          s_tick
);
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DW-1:1] == '0 && rdata[0] == busy);

  p_load_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && wdata != '0) |=> rdata[0]);

  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && reg_sel != 2'd3 && wdata == '0) |=> !rdata[0]);

  p_reg3_inert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && reg_sel == 2'd3 && !dec_evt) |=> $stable(count_q));

  p_unselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((!sel || !wr_en) && !dec_evt) |=> $stable(count_q));

  p_no_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdata[0] && !load_evt) |=> !rdata[0]);

  p_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[0]) |-> ($past(dec_evt) || $past(load_evt)));

  p_ms_on_us_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ms_tick |-> us_tick);

  p_s_on_ms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_tick |-> ms_tick);
endmodule

bind oneshot_delay_timer odt_checker #(.DW(DW)) u_odt_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .wr_en   (wr_en),
  .reg_sel (reg_sel),
  .wdata   (wdata),
  .rdata   (rdata),
  .busy    (busy),
  .dec_evt (dec_evt),
  .load_evt(load_evt),
  .count_q (count_q),
  .us_tick (us_tick),
  .ms_tick (ms_tick),
  .s_tick  (s_tick)
);

// File: tb/oneshot_delay_timer_bench.sv
module oneshot_delay_timer_bench;
  localparam int unsigned CLK_HZ    = 3_000_000;
  localparam int unsigned US_PER_MS = 5;
  localparam int unsigned MS_PER_S  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int remaining = 0;
  bit started = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  oneshot_delay_timer #(
    .CLK_HZ(CLK_HZ), .US_PER_MS(US_PER_MS), .MS_PER_S(MS_PER_S)
  ) u_oneshot_delay_timer (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata)
  );

  function automatic int unit_cycles(input int rs);
    int us_c = CLK_HZ / 1_000_000;
    if (rs == 0) return us_c;
    if (rs == 1) return us_c * US_PER_MS;
    return us_c * US_PER_MS * MS_PER_S;
  endfunction

  // Reference model: cycles of busy left.
  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) remaining = 0;
    else if (sel && wr_en && reg_sel != 2'd3) remaining = int'(wdata) * unit_cycles(int'(reg_sel));
    else if (remaining > 0) remaining = remaining - 1;
  end

  always @(negedge clk) begin
    if (started) begin
      logic [7:0] exp_v;
      exp_v = {7'd0, remaining > 0};
      checks++;
      if (rdata !== exp_v) begin
        fails++;
        $display("FAIL %s: rdata=%h expected %h (cycle %0d)", tag, rdata, exp_v, cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic s, input logic w, input logic [1:0] rs, input logic [7:0] v);
    @(negedge clk);
    sel = s; wr_en = w; reg_sel = rs; wdata = v;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0; wdata = 8'd0;
  endtask

  initial begin
    tag = "R1"; idle(3); rst_n = 1'b1; idle(4);
    tag = "R2"; bus_write(1, 1, 2'd0, 8'd4); idle(20);
    tag = "R2"; idle(1); bus_write(1, 1, 2'd0, 8'd1); idle(6);
    tag = "R3"; bus_write(1, 1, 2'd1, 8'd3); idle(55);
    tag = "R4"; bus_write(1, 1, 2'd2, 8'd2); idle(130);
    tag = "R4"; bus_write(1, 1, 2'd2, 8'd1); idle(70);
    tag = "R5"; bus_write(1, 1, 2'd0, 8'd10); idle(5);
    bus_write(1, 1, 2'd3, 8'd0); idle(2); bus_write(1, 1, 2'd3, 8'd77); idle(30);
    tag = "R6"; bus_write(1, 1, 2'd1, 8'd2); idle(4);
    bus_write(1'b0, 1, 2'd0, 8'd0); bus_write(1, 1'b0, 2'd2, 8'd0);
    bus_write(1'b0, 1, 2'd2, 8'd200); idle(40);
    tag = "R7"; bus_write(1, 1, 2'd2, 8'd0); idle(5);
    bus_write(1, 1, 2'd1, 8'd6); idle(9); bus_write(1, 1, 2'd0, 8'd0); idle(10);
    tag = "R8"; bus_write(1, 1, 2'd1, 8'd5); idle(11); bus_write(1, 1, 2'd0, 8'd2); idle(12);
    tag = "R8"; bus_write(1, 1, 2'd0, 8'd9); idle(7); bus_write(1, 1, 2'd2, 8'd1); idle(70);
    tag = "R9"; bus_write(1, 1, 2'd0, 8'd20);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); reg_sel = 2'(i);
    end
    idle(50);
    tag = "R2"; bus_write(1, 1, 2'd0, 8'd255); idle(770);
    tag = "R10"; idle(200);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule